// File: doc/BRIEF.md
# Real-Time Counter with Alarm and Periodic Wakeup

This block keeps time in a low-power domain. One of four source tick inputs is picked, passed through two optional divider stages (512 and 32, which chain to 16384), and the result advances a 32-bit up-counter. Software reads the counter over a small register bus but cannot write it. The counter can only be returned to zero by turning its run bit off and then on again.

Two event sources share one interrupt line. The alarm fires once, when the counter reaches a non-zero compare value. The wakeup timer is independent of the run bit and fires every programmed number of prescaled ticks while it is switched on. Each source has a sticky status flag that is cleared by writing a one to it. A compare update is treated as if it had to cross into the slow domain: a busy bit stays high for three prescaled ticks after each accepted compare write, and compare writes made while it is high are dropped.

Top module: `rtcw_top`

## Requirements
- R1: After reset every register reads 0 and `irq` is low. Word offsets: control 0x00, status 0x04, counter 0x08, compare 0x0C, wake interval 0x10; any other offset reads 0.
- R2: While the run bit (control bit 0) is 1, the counter rises by exactly one per prescaled tick. A bus write to offset 0x08 has no effect.
- R3: A control write that sets the run bit while it is 0 zeroes the counter and the divider stages. While the run bit is 0 the counter holds its value.
- R4: Control bit 4 enables the divide-by-512 stage and bit 5 the divide-by-32 stage. After enabling, N source ticks give floor(N/D) counts, with D = 1, 512, 32 or 16384.
- R5: Control bits [7:6] pick `src_tick` bit 0 to 3. Code 3 is reserved, and a write carrying it leaves the select field unchanged.
- R6: While the run bit is 1, writes to control bits [7:4] are ignored. Bits [3:0] are still written.
- R7: Status bit 0 (alarm) is set on the tick at which the counter becomes equal to a non-zero compare value. `irq` follows it when control bit 1 is 1.
- R8: Status bit 2 (busy) is 1 for 3 prescaled ticks after an accepted compare write. A compare write made while busy is 1 is dropped.
- R9: While control bit 2 is 1, status bit 1 (wake) is set every interval ticks (offset 0x10, interval 0 never fires). The wake count restarts from zero after each event.
- R10: Writing 1 to status bit 0 or 1 clears that flag. Writing 0 leaves it set.
- R11: `irq` is high exactly when (alarm flag AND control bit 1) OR (wake flag AND control bit 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 4 | Per-source tick enables, one per selectable clock |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that software never rewrites the compare register on the very tick at which the counter reaches the old value, because the alarm check then compares against a value that has just changed. They further assume that the source ticks are single-cycle enables in the bus clock domain. The stimulus keeps to these assumptions in three ways. It drives every input at falling edges. It writes the compare register only while the counter is far below the target. It runs the counter from source 0, which ticks every cycle, whenever exact tick counts matter.

// File: rtl/rtcw_pkg.sv
// Shared constants and types for the real-time counter block.
// Assumes byte offsets on a 5-bit address and a 2-bit source select.
package rtcw_pkg;
    localparam int ADDR_W = 5;
    localparam int SEL_W  = 2;
    localparam int NCODE  = 1 << SEL_W;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CMP  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_WAKE = 5'h10;

    localparam int ST_ALARM = 0;
    localparam int ST_WAKE  = 1;
    localparam int ST_BUSY  = 2;

    // Control layout, LSB first: run, alarm_ie, wake_run, wake_ie, pre512, pre32, sel
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             pre32;
        logic             pre512;
        logic             wake_ie;
        logic             wake_run;
        logic             alarm_ie;
        logic             run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/rtcw_divstage.sv
// One optional divider stage: passes every input pulse when disabled,
// otherwise every DIV-th input pulse. Assumes DIV >= 2.
module rtcw_divstage #(
    parameter int DIV = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic pulse_in,
    output logic pulse_out
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt_q;
    logic          last;

    assign last      = (cnt_q == CW'(DIV - 1));
    assign pulse_out = pulse_in && (!en || last);

    // Count input pulses while enabled; wrap at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (pulse_in && en) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtcw_prescaler.sv
// Source selection followed by two chained optional divider stages.
// Assumes each src_tick bit is a one-cycle enable in the clk domain.
module rtcw_prescaler import rtcw_pkg::*; #(
    parameter int DIV_A = 512,
    parameter int DIV_B = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [NCODE-1:0] src_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             en_a,
    input  logic             en_b,
    output logic             tick
);
    localparam int NST = 2;
    localparam int DIVS [NST] = '{DIV_A, DIV_B};

    logic [NST:0]   pulse;
    logic [NST-1:0] en;

    assign pulse[0] = src_tick[sel];
    assign en       = {en_b, en_a};
    assign tick     = pulse[NST];

    for (genvar g = 0; g < NST; g++) begin : g_stage
        rtcw_divstage #(.DIV(DIVS[g])) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .en        (en[g]),
            .pulse_in  (pulse[g]),
            .pulse_out (pulse[g+1])
        );
    end
endmodule

// File: rtl/rtcw_regs.sv
// Register file: control, compare and interval storage, write gating,
// flag-clear strobes and read multiplexer. Assumes single-cycle accesses.
module rtcw_regs import rtcw_pkg::*; #(
    parameter int               CNT_W    = 32,
    parameter logic [NCODE-1:0] RSV_MASK = 4'b1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              alarm_flag,
    input  logic              wake_flag,
    input  logic              busy,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic [CNT_W-1:0]  intv_q,
    output logic              run_rise,
    output logic              cmp_wr,
    output logic [1:0]        flag_clr
);
    logic  wr_ctrl, wr_stat, wr_cmp, wr_wake;
    ctrl_t wr_val;

    assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
    assign wr_stat  = bus_sel && bus_wr && (bus_addr == OFS_STAT);
    assign wr_cmp   = bus_sel && bus_wr && (bus_addr == OFS_CMP);
    assign wr_wake  = bus_sel && bus_wr && (bus_addr == OFS_WAKE);
    assign wr_val   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign run_rise = wr_ctrl && wr_val.run && !ctrl_q.run;
    assign cmp_wr   = wr_cmp && !busy;
    assign flag_clr = wr_stat ? bus_wdata[1:0] : 2'b00;

    // Control register: enables always, clock setup only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.run      <= wr_val.run;
            ctrl_q.alarm_ie <= wr_val.alarm_ie;
            ctrl_q.wake_run <= wr_val.wake_run;
            ctrl_q.wake_ie  <= wr_val.wake_ie;
            if (!ctrl_q.run) begin
                ctrl_q.pre512 <= wr_val.pre512;
                ctrl_q.pre32  <= wr_val.pre32;
                if (!RSV_MASK[wr_val.sel]) begin
                    ctrl_q.sel <= wr_val.sel;
                end
            end
        end
    end

    // Compare register: accepted only while no update is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_wr) begin
            cmp_q <= bus_wdata[CNT_W-1:0];
        end
    end

    // Wake interval register: plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intv_q <= '0;
        end else if (wr_wake) begin
            intv_q <= bus_wdata[CNT_W-1:0];
        end
    end

    // Read multiplexer, zero for unmapped offsets.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: bus_rdata = 32'(ctrl_q);
            OFS_STAT: bus_rdata = 32'({busy, wake_flag, alarm_flag});
            OFS_CNT:  bus_rdata = 32'(count);
            OFS_CMP:  bus_rdata = 32'(cmp_q);
            OFS_WAKE: bus_rdata = 32'(intv_q);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtcw_timers.sv
// Main counter, alarm compare, compare-update busy window and periodic
// wake timer, all advancing on the prescaled tick.
module rtcw_timers #(
    parameter int CNT_W      = 32,
    parameter int BUSY_TICKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             run_rise,
    input  logic             wake_run,
    input  logic [CNT_W-1:0] cmp_q,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] intv_q,
    input  logic [1:0]       flag_clr,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] wake_cnt_q,
    output logic             alarm_flag,
    output logic             wake_flag,
    output logic             busy
);
    localparam int BW = $clog2(BUSY_TICKS + 1);

    logic [BW-1:0] busy_q;
    logic          alarm_hit, wake_hit;

    assign busy      = (busy_q != '0);
    assign alarm_hit = run && tick && !run_rise && (cmp_q != '0) && (count_q + 1'b1 == cmp_q);
    assign wake_hit  = wake_run && tick && (intv_q != '0) && (wake_cnt_q + 1'b1 == intv_q);

    // Main counter: zeroed on run enable, advances on ticks while running.
    always_ff @(posedge clk) begin
        if (!rst_n || run_rise) begin
            count_q <= '0;
        end else if (run && tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Busy window: loaded on accepted compare write, drained by ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else if (cmp_wr) begin
            busy_q <= BW'(BUSY_TICKS);
        end else if (tick && busy) begin
            busy_q <= busy_q - 1'b1;
        end
    end

    // Wake counter: held at zero when off, restarts after each event.
    always_ff @(posedge clk) begin
        if (!rst_n || !wake_run) begin
            wake_cnt_q <= '0;
        end else if (wake_hit) begin
            wake_cnt_q <= '0;
        end else if (tick) begin
            wake_cnt_q <= wake_cnt_q + 1'b1;
        end
    end

    // Sticky flags: set by events, cleared by write-one; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_flag <= 1'b0;
            wake_flag  <= 1'b0;
        end else begin
            if (alarm_hit)        alarm_flag <= 1'b1;
            else if (flag_clr[0]) alarm_flag <= 1'b0;
            if (wake_hit)         wake_flag  <= 1'b1;
            else if (flag_clr[1]) wake_flag  <= 1'b0;
        end
    end
endmodule

// File: rtl/rtcw_top.sv
// Real-time counter top: prescaler, register file and timers joined,
// plus the combined interrupt. Assumes src_tick is synchronous to clk.
module rtcw_top import rtcw_pkg::*; #(
    parameter int               CNT_W      = 32,
    parameter int               DIV_A      = 512,
    parameter int               DIV_B      = 32,
    parameter int               BUSY_TICKS = 3,
    parameter logic [NCODE-1:0] RSV_MASK   = 4'b1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCODE-1:0]  src_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmp_q, intv_q, count_q, wake_cnt_q;
    logic             run_rise, cmp_wr, tick;
    logic             alarm_flag, wake_flag, busy;
    logic [1:0]       flag_clr;
    logic             run_en;
    logic [3:0]       clk_cfg;

    assign run_en  = ctrl_q.run;
    assign clk_cfg = {ctrl_q.sel, ctrl_q.pre32, ctrl_q.pre512};
    assign irq     = (alarm_flag && ctrl_q.alarm_ie) || (wake_flag && ctrl_q.wake_ie);

    rtcw_regs #(.CNT_W(CNT_W), .RSV_MASK(RSV_MASK)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .count      (count_q),
        .alarm_flag (alarm_flag),
        .wake_flag  (wake_flag),
        .busy       (busy),
        .ctrl_q     (ctrl_q),
        .cmp_q      (cmp_q),
        .intv_q     (intv_q),
        .run_rise   (run_rise),
        .cmp_wr     (cmp_wr),
        .flag_clr   (flag_clr)
    );

    rtcw_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (run_rise),
        .src_tick (src_tick),
        .sel      (ctrl_q.sel),
        .en_a     (ctrl_q.pre512),
        .en_b     (ctrl_q.pre32),
        .tick     (tick)
    );

    rtcw_timers #(.CNT_W(CNT_W), .BUSY_TICKS(BUSY_TICKS)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .run        (ctrl_q.run),
        .run_rise   (run_rise),
        .wake_run   (ctrl_q.wake_run),
        .cmp_q      (cmp_q),
        .cmp_wr     (cmp_wr),
        .intv_q     (intv_q),
        .flag_clr   (flag_clr),
        .count_q    (count_q),
        .wake_cnt_q (wake_cnt_q),
        .alarm_flag (alarm_flag),
        .wake_flag  (wake_flag),
        .busy       (busy)
    );
endmodule

// File: rtl/rtcw_checker.sv
// Temporal checks on the real-time counter, bound into rtcw_top.
// Assumes reset is held for at least one clock edge.
module rtcw_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [4:0]       bus_addr,
    input logic             run_en,
    input logic             run_rise,
    input logic [3:0]       clk_cfg,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] cmp_q,
    input logic [CNT_W-1:0] wake_cnt_q,
    input logic             alarm_flag,
    input logic             wake_flag,
    input logic             busy,
    input logic             irq
);
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1) || (count_q == '0));

    a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run_en) && !$past(run_rise)) |-> $stable(count_q));

    a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run_en) |-> $stable(clk_cfg));

    a_r7_alarm_at_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> (count_q == cmp_q) && (cmp_q != '0));

    a_r8_busy_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_sel && bus_wr && bus_addr == 5'h0C) |=> $stable(cmp_q));

    a_r9_wake_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> (wake_cnt_q == '0));

    a_r11_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag && !wake_flag) |-> !irq);
endmodule

bind rtcw_top rtcw_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .run_en     (run_en),
    .run_rise   (run_rise),
    .clk_cfg    (clk_cfg),
    .count_q    (count_q),
    .cmp_q      (cmp_q),
    .wake_cnt_q (wake_cnt_q),
    .alarm_flag (alarm_flag),
    .wake_flag  (wake_flag),
    .busy       (busy),
    .irq        (irq)
);

// File: tb/rtcw_top_test.sv
module rtcw_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ph = 1'b0;
    logic [3:0]  src_tick;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          checks = 0, errors = 0;
    logic [31:0] v;

    // Fields: control value, source-tick edges to wait, expected count (R4, R5)
    localparam logic [63:0] VEC [0:6] = '{
        {8'h01, 24'd5,     32'd5},
        {8'h01, 24'd40,    32'd40},
        {8'h21, 24'd100,   32'd3},
        {8'h11, 24'd1023,  32'd1},
        {8'h11, 24'd1024,  32'd2},
        {8'h31, 24'd16384, 32'd1},
        {8'h81, 24'd20,    32'd0}
    };

    always #10 clk = ~clk;
    always @(posedge clk) ph <= ~ph;
    assign src_tick = {1'b0, 1'b0, ph, 1'b1};

    rtcw_top uut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; consumes exactly one rising edge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Combinational read, consumes no clock edge.
    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and map
        rd(5'h00, v); chk("R1 ctrl", v, 0);
        rd(5'h04, v); chk("R1 status", v, 0);
        rd(5'h08, v); chk("R1 counter", v, 0);
        rd(5'h0C, v); chk("R1 compare", v, 0);
        rd(5'h10, v); chk("R1 interval", v, 0);
        rd(5'h14, v); chk("R1 unmapped", v, 0);
        chk("R1 irq", 32'(irq), 0);

        // R4 R5 prescaler and source table
        for (int i = 0; i < 7; i++) begin
            wr(5'h00, 32'h0);
            wr(5'h00, 32'(VEC[i][63:56]));
            repeat (int'(VEC[i][55:32])) @(negedge clk);
            rd(5'h08, v); chk("R4 count after enable", v, VEC[i][31:0]);
        end

        // R6 clock setup frozen while running, enables still written
        wr(5'h00, 32'h0);
        wr(5'h00, 32'h01);
        wr(5'h00, 32'h13);
        rd(5'h00, v); chk("R6 divider ignored while running", v, 32'h03);
        // R5 reserved select code
        wr(5'h00, 32'h0);
        wr(5'h00, 32'hC0);
        rd(5'h00, v); chk("R5 reserved select kept", v, 32'h00);

        // R3 hold while stopped, R2 counter read-only
        wr(5'h00, 32'h01);
        repeat (10) @(negedge clk);
        wr(5'h00, 32'h00);
        rd(5'h08, v); chk("R2 count per tick", v, 11);
        repeat (5) @(negedge clk);
        rd(5'h08, v); chk("R3 hold while stopped", v, 11);
        wr(5'h08, 32'h1234);
        rd(5'h08, v); chk("R2 counter write ignored", v, 11);
        wr(5'h00, 32'h01);
        rd(5'h08, v); chk("R3 zero on run enable", v, 0);

        // R8 busy window and dropped write
        wr(5'h00, 32'h03);
        wr(5'h0C, 32'd20);
        rd(5'h04, v); chk("R8 busy after write", v, 32'h4);
        wr(5'h0C, 32'd5);
        rd(5'h0C, v); chk("R8 write while busy dropped", v, 20);
        rd(5'h04, v); chk("R8 still busy", v, 32'h4);
        repeat (2) @(negedge clk);
        rd(5'h04, v); chk("R8 busy cleared after 3 ticks", v, 32'h0);

        // R7 alarm, R10 write-one clear, R11 irq
        repeat (10) @(negedge clk);
        rd(5'h04, v); chk("R7 no alarm before match", v, 32'h0);
        chk("R11 irq low", 32'(irq), 0);
        repeat (10) @(negedge clk);
        rd(5'h04, v); chk("R7 alarm set", v, 32'h1);
        chk("R11 irq from alarm", 32'(irq), 1);
        wr(5'h04, 32'h0);
        rd(5'h04, v); chk("R10 write zero keeps flag", v, 32'h1);
        wr(5'h04, 32'h1);
        rd(5'h04, v); chk("R10 write one clears", v, 32'h0);
        chk("R11 irq drops", 32'(irq), 0);

        // R9 periodic wake
        wr(5'h10, 32'd4);
        wr(5'h00, 32'h0D);
        repeat (3) @(negedge clk);
        rd(5'h04, v); chk("R9 no wake before interval", v, 32'h0);
        @(negedge clk);
        rd(5'h04, v); chk("R9 wake at interval", v, 32'h2);
        chk("R11 irq from wake", 32'(irq), 1);
        wr(5'h04, 32'h2);
        rd(5'h04, v); chk("R10 wake cleared", v, 32'h0);
        repeat (3) @(negedge clk);
        rd(5'h04, v); chk("R9 wake repeats", v, 32'h2);
        wr(5'h00, 32'h05);
        rd(5'h04, v); chk("R11 flag kept", v, 32'h2);
        chk("R11 masked irq", 32'(irq), 0);

        finish_run();
    end
endmodule